// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block forms a chip's final clock output. It chooses one of two source clocks: a fast synthesized clock or a slower reference clock. It then divides the chosen source by a power of two between 1 and 128. Divide-by-1 passes the source straight through. Every other ratio is taken from one bit of a free-running binary counter on the source, so its duty cycle is exactly 50%.

A single control pin gates the output, and a gated output sits low. The pin enables the output when high in both pin modes. The modes differ in what happens to the divider while the output is off. In power-down mode the divider counter is frozen at zero. In output-enable mode the counter keeps running and only the output is masked. Gating is either asynchronous or synchronous, and this is set separately from the pin mode. Asynchronous gating forces the output low at once, and the divider restarts from zero afterwards. Synchronous gating only switches at points where the output is low, so the output never has a shortened high phase. All configuration inputs are captured while reset is asserted.

Top module: `clkout_stage`

## Requirements
- R1: With divide code k (0 to 7) the output period is 2^k periods of the selected source clock.
- R2: Source select 0 divides the synthesized clock and source select 1 divides the reference clock. All 16 combinations of source and code are available.
- R3: For codes 1 to 7 the output is high for exactly half its period. For code 0 the output follows the source clock's own high phase.
- R4: While reset is asserted the output is low.
- R5: In both pin modes a low control pin turns the output off, which holds it low, and a high control pin turns it on.
- R6: With synchronous gating, lowering the pin during a high phase does not cut that phase short. The output falls at its normal time and then stays low.
- R7: With synchronous gating, the first high phase after the pin rises is a full half period long.
- R8: With asynchronous gating, a low pin forces the output low in the same instant, including at code 0.
- R9: With asynchronous gating, the divider restarts from zero on re-enable. The pin is raised between source edges e0 and e1. The first output rise then comes at source edge e(2+2^(k-1)), for k of 1 or more.
- R10: In power-down mode with synchronous gating, the counter is held at zero while the output is off. With the pin raised between source edges e0 and e1, the first rise comes at edge e(3+2^(k-1)).
- R11: In output-enable mode with synchronous gating, the counter keeps running while the output is off. Rises after re-enable therefore fall on the same grid of whole output periods as the rises before.
- R12: The configuration inputs are sampled only while reset is asserted. A change after reset has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_syn | input | 1 | Synthesized high-frequency source clock |
| clk_ref | input | 1 | Reference source clock; also clocks the configuration capture |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 1 | Source select: 0 synthesized, 1 reference |
| cfg_div | input | 3 | Divide code k, ratio 2^k |
| cfg_pd_mode | input | 1 | 1 selects power-down pin mode, 0 selects output-enable pin mode |
| cfg_async | input | 1 | 1 selects asynchronous gating, 0 selects synchronous gating |
| ctl_pin | input | 1 | Gate control; high turns the output on |
| clk_out | output | 1 | Divided, gated clock output |

## Verification
A wrong counter tap or a wrong source selection shows up as a wrong period on the first complete output cycle. That cycle ends at most 128 source periods after reset. A gate register that updates at the wrong point shows up as a shortened high phase at the next enable or disable. The bench measures the length of each phase to the nanosecond. A counter that is not held or restarted correctly shifts the first rise after re-enable by whole source cycles. The bench catches this by timing that rise against a fixed edge count.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;
    localparam int DIV_CODE_W = 3;
    localparam int CNT_W      = (1 << DIV_CODE_W) - 1;

    typedef enum logic { SRC_SYN = 1'b0, SRC_REF = 1'b1 } src_e;
    typedef enum logic { PIN_ENABLE = 1'b0, PIN_POWERDOWN = 1'b1 } pin_mode_e;
    typedef enum logic { GATE_SYNC = 1'b0, GATE_ASYNC = 1'b1 } gate_mode_e;

    typedef struct packed {
        src_e                  src;
        logic [DIV_CODE_W-1:0] div_code;
        pin_mode_e             pin_mode;
        gate_mode_e            gate_mode;
    } out_cfg_t;

    // Counter bit whose toggling gives a 2^code ratio; code 0 has no tap.
    function automatic logic tap_bit(input logic [CNT_W-1:0] cnt,
                                     input logic [DIV_CODE_W-1:0] code);
        if (code == '0) return 1'b0;
        return cnt[code - DIV_CODE_W'(1)];
    endfunction
endpackage

// File: rtl/clkout_cfg_capture.sv
`timescale 1ns/1ps
module clkout_cfg_capture
    import clkout_pkg::*;
(
    input  logic     clk_ref,
    input  logic     rst,
    input  out_cfg_t cfg_in,
    output out_cfg_t cfg_q
);
    // Loaded on every reference edge while reset is held, frozen afterwards.
    always_ff @(posedge clk_ref) begin
        if (rst) cfg_q <= cfg_in;
    end
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider
    import clkout_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold,
    input  logic [DIV_CODE_W-1:0] code,
    output logic [CNT_W-1:0]      cnt,
    output logic                  div_bit,
    output logic                  nxt_bit
);
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        cnt_next = hold ? '0 : cnt + CNT_W'(1);
        nxt_bit  = tap_bit(cnt_next, code);
        div_bit  = tap_bit(cnt, code);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end
endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate
    import clkout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  out_cfg_t cfg,
    input  logic     div_bit,
    input  logic     nxt_bit,
    output logic     gate_q,
    output logic     en_eff,
    output logic     clk_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   gate_n;
    logic                   div1;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign div1  = (cfg.div_code == '0);

    // Divided ratios: gate switches only at edges after which the output is low.
    always_ff @(posedge clk) begin
        if (rst)          gate_q <= 1'b0;
        else if (!nxt_bit) gate_q <= pin_s;
    end

    // Pass-through ratio: gate switches while the source is low.
    always_ff @(negedge clk) begin
        if (rst) gate_n <= 1'b0;
        else     gate_n <= pin_s;
    end

    always_comb begin
        if (cfg.gate_mode == GATE_ASYNC) en_eff = pin_s;
        else if (div1)                   en_eff = gate_n;
        else                             en_eff = gate_q;

        if (rst)
            clk_out = 1'b0;
        else if (cfg.gate_mode == GATE_ASYNC)
            clk_out = (div1 ? clk : div_bit) & pin;
        else
            clk_out = div1 ? (clk & gate_n) : (div_bit & gate_q);
    end
endmodule

// File: rtl/clkout_stage.sv
`timescale 1ns/1ps
module clkout_stage
    import clkout_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_syn,
    input  logic       clk_ref,
    input  logic       rst,
    input  logic       cfg_src,
    input  logic [2:0] cfg_div,
    input  logic       cfg_pd_mode,
    input  logic       cfg_async,
    input  logic       ctl_pin,
    output logic       clk_out
);
    out_cfg_t         cfg_in;
    out_cfg_t         cfg_q;
    logic             src_clk;
    logic             hold;
    logic [CNT_W-1:0] cnt;
    logic             div_bit;
    logic             nxt_bit;
    logic             gate_q;
    logic             en_eff;

    assign cfg_in = '{src:       src_e'(cfg_src),
                      div_code:  cfg_div,
                      pin_mode:  pin_mode_e'(cfg_pd_mode),
                      gate_mode: gate_mode_e'(cfg_async)};

    clkout_cfg_capture u_cfg (
        .clk_ref (clk_ref),
        .rst     (rst),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q)
    );

    assign src_clk = (cfg_q.src == SRC_REF) ? clk_ref : clk_syn;

    // Counter freezes while off in power-down mode, and restarts after any async gate.
    assign hold = ((cfg_q.pin_mode == PIN_POWERDOWN) || (cfg_q.gate_mode == GATE_ASYNC))
                  && !en_eff;

    clkout_divider u_div (
        .clk     (src_clk),
        .rst     (rst),
        .hold    (hold),
        .code    (cfg_q.div_code),
        .cnt     (cnt),
        .div_bit (div_bit),
        .nxt_bit (nxt_bit)
    );

    clkout_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk     (src_clk),
        .rst     (rst),
        .pin     (ctl_pin),
        .cfg     (cfg_q),
        .div_bit (div_bit),
        .nxt_bit (nxt_bit),
        .gate_q  (gate_q),
        .en_eff  (en_eff),
        .clk_out (clk_out)
    );
endmodule

// File: rtl/clkout_stage_chk.sv
`timescale 1ns/1ps
module clkout_stage_chk
    import clkout_pkg::*;
(
    input logic             src_clk,
    input logic             rst,
    input logic             ctl_pin,
    input logic             clk_out,
    input out_cfg_t         cfg_q,
    input logic [CNT_W-1:0] cnt,
    input logic             gate_q,
    input logic             div_bit,
    input logic             en_eff
);
    logic sync_div;
    assign sync_div = (cfg_q.gate_mode == GATE_SYNC) && (cfg_q.div_code != '0);

    always_comb begin
        if (rst) a_r4_low_in_reset: assert (clk_out == 1'b0);
    end

    always_comb begin
        if (!rst && cfg_q.gate_mode == GATE_ASYNC && !ctl_pin)
            a_r8_async_forced_low: assert (clk_out == 1'b0);
    end

    a_r7_rise_needs_gate: assert property (@(posedge src_clk) disable iff (rst)
        (sync_div && clk_out && !$past(clk_out)) |-> $past(gate_q));

    a_r6_gate_moves_when_low: assert property (@(posedge src_clk) disable iff (rst)
        (sync_div && !$stable(gate_q)) |-> !div_bit);

    a_r10_pd_holds_counter: assert property (@(posedge src_clk) disable iff (rst)
        (cfg_q.pin_mode == PIN_POWERDOWN && !en_eff) |=> (cnt == '0));
endmodule

bind clkout_stage clkout_stage_chk u_chk (
    .src_clk (src_clk),
    .rst     (rst),
    .ctl_pin (ctl_pin),
    .clk_out (clk_out),
    .cfg_q   (cfg_q),
    .cnt     (cnt),
    .gate_q  (gate_q),
    .div_bit (div_bit),
    .en_eff  (en_eff)
);

// File: tb/tb_clkout_stage.sv
`timescale 1ns/1ps
module tb_clkout_stage;
    logic       clk_syn = 1'b0;
    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_src = 1'b0;
    logic [2:0] cfg_div = 3'd0;
    logic       cfg_pd_mode = 1'b0;
    logic       cfg_async = 1'b0;
    logic       ctl_pin = 1'b1;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4  clk_syn = ~clk_syn;   // 125 MHz
    always #10 clk_ref = ~clk_ref;

    clkout_stage dut (
        .clk_syn     (clk_syn),
        .clk_ref     (clk_ref),
        .rst         (rst),
        .cfg_src     (cfg_src),
        .cfg_div     (cfg_div),
        .cfg_pd_mode (cfg_pd_mode),
        .cfg_async   (cfg_async),
        .ctl_pin     (ctl_pin),
        .clk_out     (clk_out)
    );

    // {src, code} and expected output period in ns
    localparam logic [3:0] VEC_IN[16] = '{
        4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7,
        4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
    localparam int VEC_PER[16] = '{
        8, 16, 32, 64, 128, 256, 512, 1024,
        20, 40, 80, 160, 320, 640, 1280, 2560};

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic src, input logic [2:0] code,
                               input logic pd, input logic as);
        @(posedge clk_syn); #2;
        rst = 1'b1; cfg_src = src; cfg_div = code; cfg_pd_mode = pd; cfg_async = as;
        repeat (4) @(posedge clk_ref);
        @(posedge clk_syn); #1;
        chk(clk_out == 1'b0, "R4 low in reset", real'(clk_out), 0.0);
        repeat (2) @(posedge clk_ref);
        @(posedge clk_syn); #2;
        rst = 1'b0;
    endtask

    task automatic measure(output real per, output real hi);
        real t0, t1, t2;
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic count_high(input int samples, output int highs);
        highs = 0;
        @(posedge clk_syn); #1;
        for (int i = 0; i < samples; i++) begin
            if (clk_out) highs++;
            #2;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_syn);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        real per, hi, ts, t0, t1, tb, tf, d;
        int  highs;

        // R1 R2 R3: all sources and ratios, output-enable, sync gating
        for (int v = 0; v < 16; v++) begin
            ctl_pin = 1'b1;
            apply_reset(VEC_IN[v][3], VEC_IN[v][2:0], 1'b0, 1'b0);
            @(posedge clk_out);
            measure(per, hi);
            chk(per == real'(VEC_PER[v]), "R1/R2 period", per, real'(VEC_PER[v]));
            chk(hi == real'(VEC_PER[v]) / 2.0, "R3 high phase", hi, real'(VEC_PER[v]) / 2.0);
        end

        // R12: configuration changed after reset is ignored
        apply_reset(1'b0, 3'd3, 1'b0, 1'b0);
        cfg_div = 3'd5; cfg_src = 1'b1; cfg_async = 1'b1; cfg_pd_mode = 1'b1;
        measure(per, hi);
        measure(per, hi);
        chk(per == 64.0, "R12 config frozen", per, 64.0);

        // R6: sync disable during a high phase completes the phase
        @(posedge clk_out); t0 = $realtime;
        #5 ctl_pin = 1'b0;
        @(negedge clk_out); t1 = $realtime;
        chk((t1 - t0) == 32.0, "R6 high phase not cut", t1 - t0, 32.0);
        count_high(100, highs);
        chk(highs == 0, "R5 off holds low (enable mode)", real'(highs), 0.0);

        // R7 R11: re-enable gives full high phase on the original grid
        @(posedge clk_syn); #3 ctl_pin = 1'b1;
        @(posedge clk_out); tb = $realtime;
        @(negedge clk_out); tf = $realtime;
        chk((tf - tb) == 32.0, "R7 first high full", tf - tb, 32.0);
        d = real'($rtoi(tb - t0 + 0.5) % 64);
        chk(d == 0.0, "R11 grid kept", d, 0.0);

        // R10 R5: power-down, sync gating
        apply_reset(1'b0, 3'd3, 1'b1, 1'b0);
        measure(per, hi);
        chk(per == 64.0, "R5 power-down mode runs when pin high", per, 64.0);
        #7 ctl_pin = 1'b0;
        #200;
        count_high(100, highs);
        chk(highs == 0, "R5 power-down pin low holds low", real'(highs), 0.0);
        @(posedge clk_syn); #4 ctl_pin = 1'b1; ts = $realtime;
        @(posedge clk_out);
        chk(($realtime - ts) == 52.0, "R10 restart from held counter", $realtime - ts, 52.0);

        // R8 R9: async gating, output-enable mode
        apply_reset(1'b0, 3'd3, 1'b0, 1'b1);
        @(posedge clk_out); #3 ctl_pin = 1'b0;
        #1;
        chk(clk_out == 1'b0, "R8 async immediate low", real'(clk_out), 0.0);
        #200;
        @(posedge clk_syn); #4 ctl_pin = 1'b1; ts = $realtime;
        @(posedge clk_out);
        chk(($realtime - ts) == 44.0, "R9 async restart delay", $realtime - ts, 44.0);

        // R8 at code 0
        apply_reset(1'b0, 3'd0, 1'b0, 1'b1);
        ctl_pin = 1'b0;
        count_high(60, highs);
        chk(highs == 0, "R8 async code0 low", real'(highs), 0.0);
        ctl_pin = 1'b1;
        count_high(60, highs);
        chk(highs > 0, "R5 async code0 on", real'(highs), 30.0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule